// File: doc/BRIEF.md
# Power-Up Automatic Page Download Sequencer

This block is the device side of a small-page NAND boot path. A host that boots from the array has no command sequence to issue. When the power-good input rises, the sequencer copies page 0 from the array into an internal page buffer by itself, with no command or address phase. It holds the ready/busy output low for a fixed number of clock cycles during the copy. It then presents the buffered bytes on an 8-bit data output, one new byte for each read-enable pulse.

A configuration input picks one of two behaviours:

- **Single-page mode.** Only page 0 is downloaded, and chip enable is not looked at.
- **Continuous mode.** After the last byte of a page the sequencer starts a new busy interval and loads the next page. It continues until the last byte of the last page.

In continuous mode, chip enable going high stops the download. In either mode, a command-latch strobe stops it. Once stopped or finished, the sequencer stays idle until power-good falls and rises again.

The array is reached through a synchronous read port: the address and enable are registered, and the data returns one cycle later. The busy interval must be at least two cycles longer than a page.

Top module: `pup_page_streamer`

## Requirements
- R1: While `pwr_good` is low, `rdy_n_busy` is high, `dq_out` is zero and `arr_rd_en` is low.
- R2: A rising `pwr_good` starts the copy of page 0 with no command: `rdy_n_busy` is low from the next clock on. Array reads happen only while `rdy_n_busy` is low.
- R3: Without an abort, `rdy_n_busy` stays low for exactly `BUSY_CYCLES` cycles per page, and `dq_out` is zero while it is low.
- R4: When ready, `dq_out` shows byte 0 of the loaded page. Each read-enable pulse advances to the next byte of that page in address order. The advance happens on the low-to-high return of `rd_en_n`, three clocks after the pin rises.
- R5: Read-enable pulses that occur while busy are ignored: the first byte shown after the busy interval is byte 0.
- R6: In single-page mode (`one_page_only` = 1), a pulse on the last byte of page 0 ends the download. `rdy_n_busy` stays high, `dq_out` is 0, and no further busy interval follows.
- R7: In continuous mode (`one_page_only` = 0), a pulse on the last byte of page p < last starts a new busy interval. Afterwards `dq_out` shows byte 0 of page p+1, which is array address (p+1)·PAGE_BYTES.
- R8: In continuous mode, a pulse on the last byte of the last page ends the download, with no further busy interval.
- R9: In continuous mode, `chip_en_n` high during busy or during output ends the download: `rdy_n_busy` goes high and `dq_out` goes to zero.
- R10: A `cmd_latch` pulse ends the download in either mode, and a busy interval ends on the next clock.
- R11: In single-page mode, `chip_en_n` has no effect on loading or byte output.
- R12: After the download ends, the sequencer stays idle with zero output, whatever read-enable does, until `pwr_good` falls and rises again. That restarts the sequence from page 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply-good indication; a rising edge starts the download |
| chip_en_n | input | 1 | Active-low chip enable (synchronized inside) |
| rd_en_n | input | 1 | Active-low read-enable strobe (synchronized inside) |
| cmd_latch | input | 1 | Command-latch strobe; high aborts the download |
| one_page_only | input | 1 | 1: page 0 only, chip enable ignored; 0: continuous download |
| rdy_n_busy | output | 1 | Ready (high) / busy (low) |
| dq_out | output | 8 | Data output byte |
| arr_addr | output | AW | Array byte address, where AW = clog2(PAGE_BYTES·PAGE_COUNT) |
| arr_rd_en | output | 1 | Array read enable |
| arr_rdata | input | 8 | Array read data, one cycle after the enable |

## Verification
The hardest state to reach from the ports is a read-enable edge that arrives during a busy interval. Such an edge must not leave a pending advance once the buffer is ready. To reach it, the bench toggles read-enable throughout most of the first busy interval and stops early enough that the last synchronized edge still falls inside it. It then checks that byte 0 is shown.

Page rollover in continuous mode is the other hard case, because it needs a full page of pulses. The bench uses a small page and page count so that rollover and the end of memory are both reached.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_BUSY  = 2'd1,
        ST_READY = 2'd2,
        ST_HALT  = 2'd3
    } seq_state_t;

    typedef logic [7:0] byte_t;

    function automatic int width_of(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pps_sync.sv
module pps_sync #(
    parameter int             W       = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/pps_page_buf.sv
module pps_page_buf #(
    parameter int DEPTH = 528,
    parameter int IW    = 10
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic [IW-1:0]  wr_idx,
    input  pps_pkg::byte_t wr_data,
    input  logic [IW-1:0]  rd_idx,
    output pps_pkg::byte_t rd_data
);
    pps_pkg::byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/pps_copy_engine.sv
module pps_copy_engine #(
    parameter int PAGE_BYTES  = 528,
    parameter int PAGE_COUNT  = 8,
    parameter int BUSY_CYCLES = 600,
    parameter int BW  = pps_pkg::width_of(PAGE_BYTES),
    parameter int PGW = pps_pkg::width_of(PAGE_COUNT),
    parameter int AW  = pps_pkg::width_of(PAGE_BYTES * PAGE_COUNT)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           kill,
    input  logic [PGW-1:0] page_idx,
    output logic           done,
    output logic [AW-1:0]  arr_addr,
    output logic           arr_rd_en,
    output logic           wr_en,
    output logic [BW-1:0]  wr_idx
);
    localparam int CW = pps_pkg::width_of(BUSY_CYCLES + 1);

    logic          active;
    logic [CW-1:0] cnt;

    // Interval timer: one array byte per clock for the first PAGE_BYTES counts.
    always_ff @(posedge clk) begin
        if (rst || kill) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (cnt == CW'(BUSY_CYCLES - 1)) active <= 1'b0;
            else                             cnt    <= cnt + 1'b1;
        end
    end

    assign done      = active && (cnt == CW'(BUSY_CYCLES - 1));
    assign arr_rd_en = active && (cnt < CW'(PAGE_BYTES));
    assign arr_addr  = AW'(page_idx) * AW'(PAGE_BYTES) + AW'(cnt);

    // Read data returns one clock later; the buffer write follows it.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en  <= 1'b0;
            wr_idx <= '0;
        end else begin
            wr_en  <= arr_rd_en && !kill;
            wr_idx <= BW'(cnt);
        end
    end
endmodule

// File: rtl/pup_page_streamer.sv
module pup_page_streamer #(
    parameter int PAGE_BYTES  = 528,
    parameter int PAGE_COUNT  = 8,
    parameter int BUSY_CYCLES = 600,
    parameter int AW = pps_pkg::width_of(PAGE_BYTES * PAGE_COUNT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_good,
    input  logic          chip_en_n,
    input  logic          rd_en_n,
    input  logic          cmd_latch,
    input  logic          one_page_only,
    output logic          rdy_n_busy,
    output logic [7:0]    dq_out,
    output logic [AW-1:0] arr_addr,
    output logic          arr_rd_en,
    input  logic [7:0]    arr_rdata
);
    import pps_pkg::*;

    localparam int BW  = width_of(PAGE_BYTES);
    localparam int PGW = width_of(PAGE_COUNT);

    seq_state_t     state, nxt_state;
    logic [PGW-1:0] page, nxt_page;
    logic [BW-1:0]  ptr, nxt_ptr;
    logic           pg_q, re_prev;
    logic [1:0]     sync_q;
    logic           ce_s, re_s, re_rise, start_req, abort_req;
    logic           eng_start, eng_kill, eng_done, buf_we;
    logic [BW-1:0]  buf_widx;
    byte_t          buf_rd;

    pps_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk (clk), .rst (rst),
        .d   ({chip_en_n, rd_en_n}),
        .q   (sync_q)
    );
    assign ce_s = sync_q[1];
    assign re_s = sync_q[0];

    assign re_rise   = re_s && !re_prev;
    assign start_req = pwr_good && !pg_q;
    assign abort_req = cmd_latch || (!one_page_only && ce_s);

    always_comb begin
        nxt_state = state;
        nxt_page  = page;
        nxt_ptr   = ptr;
        if (!pwr_good) begin
            nxt_state = ST_OFF;
        end else if (start_req) begin
            nxt_state = ST_BUSY;
            nxt_page  = '0;
            nxt_ptr   = '0;
        end else begin
            case (state)
                ST_BUSY: begin
                    if (abort_req)     nxt_state = ST_HALT;
                    else if (eng_done) begin
                        nxt_state = ST_READY;
                        nxt_ptr   = '0;
                    end
                end
                ST_READY: begin
                    if (abort_req) begin
                        nxt_state = ST_HALT;
                    end else if (re_rise) begin
                        if (ptr == BW'(PAGE_BYTES - 1)) begin
                            if (one_page_only || page == PGW'(PAGE_COUNT - 1)) begin
                                nxt_state = ST_HALT;
                            end else begin
                                nxt_state = ST_BUSY;
                                nxt_page  = page + 1'b1;
                                nxt_ptr   = '0;
                            end
                        end else begin
                            nxt_ptr = ptr + 1'b1;
                        end
                    end
                end
                default: nxt_state = state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_OFF;
            page    <= '0;
            ptr     <= '0;
            pg_q    <= 1'b0;
            re_prev <= 1'b1;
        end else begin
            state   <= nxt_state;
            page    <= nxt_page;
            ptr     <= nxt_ptr;
            pg_q    <= pwr_good;
            re_prev <= re_s;
        end
    end

    assign eng_start = (nxt_state == ST_BUSY) && (state != ST_BUSY || start_req);
    assign eng_kill  = (state == ST_BUSY) && (nxt_state != ST_BUSY);

    pps_copy_engine #(
        .PAGE_BYTES (PAGE_BYTES), .PAGE_COUNT (PAGE_COUNT),
        .BUSY_CYCLES(BUSY_CYCLES), .BW(BW), .PGW(PGW), .AW(AW)
    ) u_copy (
        .clk      (clk),
        .rst      (rst),
        .start    (eng_start),
        .kill     (eng_kill && !eng_start),
        .page_idx (nxt_page),
        .done     (eng_done),
        .arr_addr (arr_addr),
        .arr_rd_en(arr_rd_en),
        .wr_en    (buf_we),
        .wr_idx   (buf_widx)
    );

    pps_page_buf #(.DEPTH(PAGE_BYTES), .IW(BW)) u_buf (
        .clk    (clk),
        .wr_en  (buf_we),
        .wr_idx (buf_widx),
        .wr_data(arr_rdata),
        .rd_idx (ptr),
        .rd_data(buf_rd)
    );

    assign rdy_n_busy = (state != ST_BUSY);
    assign dq_out     = (state == ST_READY) ? buf_rd : 8'h00;
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
    parameter int BUSY_CYCLES = 600
) (
    input logic       clk,
    input logic       rst,
    input logic       pwr_good,
    input logic       cmd_latch,
    input logic       rdy_n_busy,
    input logic [7:0] dq_out,
    input logic       arr_rd_en
);
    int unsigned low_run;

    always_ff @(posedge clk) begin
        if (rst)              low_run <= 0;
        else if (!rdy_n_busy) low_run <= low_run + 1;
        else                  low_run <= 0;
    end

    // R1
    power_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> (rdy_n_busy && dq_out == 8'h00));

    // R2
    auto_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_good) |=> !rdy_n_busy);

    // R2
    read_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        arr_rd_en |-> !rdy_n_busy);

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        !rdy_n_busy |-> (low_run < BUSY_CYCLES && dq_out == 8'h00));

    // R10
    cmd_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_latch && !rdy_n_busy && pwr_good) |=> rdy_n_busy);
endmodule

bind pup_page_streamer pps_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_good  (pwr_good),
    .cmd_latch (cmd_latch),
    .rdy_n_busy(rdy_n_busy),
    .dq_out    (dq_out),
    .arr_rd_en (arr_rd_en)
);

// File: tb/sim_pup_page_streamer.sv
module sim_pup_page_streamer;
    localparam int PB  = 16;
    localparam int PC  = 3;
    localparam int BC  = 20;
    localparam int AWB = $clog2(PB * PC);
    localparam int NSTEP = 6;
    localparam int STEP [NSTEP] = '{1, 1, 2, 3, 4, 4};

    logic           clk = 1'b0;
    logic           rst, pwr_good, chip_en_n, rd_en_n, cmd_latch, one_page_only;
    logic           rdy_n_busy, arr_rd_en;
    logic [7:0]     dq_out, arr_rdata;
    logic [AWB-1:0] arr_addr;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    pup_page_streamer #(.PAGE_BYTES(PB), .PAGE_COUNT(PC), .BUSY_CYCLES(BC)) u0 (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .chip_en_n(chip_en_n),
        .rd_en_n(rd_en_n), .cmd_latch(cmd_latch), .one_page_only(one_page_only),
        .rdy_n_busy(rdy_n_busy), .dq_out(dq_out), .arr_addr(arr_addr),
        .arr_rd_en(arr_rd_en), .arr_rdata(arr_rdata)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    always @(posedge clk) begin
        if (arr_rd_en) arr_rdata <= pat(int'(arr_addr));
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic pulse();
        @(negedge clk) rd_en_n = 1'b0;
        repeat (4) @(negedge clk);
        rd_en_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_ready(output int low);
        low = 0;
        @(negedge clk);
        while (!rdy_n_busy && low < 10000) begin
            low++;
            @(negedge clk);
        end
    endtask

    task automatic power_cycle(output int low);
        @(negedge clk) pwr_good = 1'b0;
        repeat (3) @(negedge clk);
        pwr_good = 1'b1;
        wait_ready(low);
    endtask

    task automatic count_low(input int n, output int low);
        low = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!rdy_n_busy) low++;
        end
    endtask

    initial begin
        int low, idx, first_low;
        rst = 1'b1; pwr_good = 1'b0; chip_en_n = 1'b0; rd_en_n = 1'b1;
        cmd_latch = 1'b0; one_page_only = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1: powered-off state
        check("R1 ready", int'(rdy_n_busy), 1);
        check("R1 dq", int'(dq_out), 0);
        check("R1 rd_en", int'(arr_rd_en), 0);

        // R2 R3 R5: start on power-good, with read-enable toggling while busy
        pwr_good = 1'b1;
        low = 0; first_low = 0;
        for (int i = 1; i <= BC + 3; i++) begin
            @(negedge clk);
            if (!rdy_n_busy) low++;
            if (i == 1) first_low = int'(!rdy_n_busy);
            rd_en_n = (i < BC - 6) ? i[1] : 1'b1;
        end
        check("R2 busy after power-good", first_low, 1);
        check("R3 busy length", low, BC);
        check("R5 byte 0 after ignored pulses", int'(dq_out), int'(pat(0)));

        // R4: table walk through page 0
        idx = 0;
        for (int k = 0; k < NSTEP; k++) begin
            repeat (STEP[k]) pulse();
            idx += STEP[k];
            check("R4 byte order", int'(dq_out), int'(pat(idx)));
        end

        // R6: end of page 0 in single-page mode
        pulse();
        check("R6 ready after end", int'(rdy_n_busy), 1);
        check("R6 dq zero", int'(dq_out), 0);
        count_low(2 * BC, low);
        check("R6 no new busy", low, 0);

        // R12: halt persists under read-enable pulses
        pulse(); pulse();
        check("R12 halted dq", int'(dq_out), 0);
        check("R12 halted ready", int'(rdy_n_busy), 1);

        // R11 R12: restart with chip enable high in single-page mode
        chip_en_n = 1'b1;
        power_cycle(low);
        check("R11 busy length ce high", low, BC);
        check("R12 restart byte 0", int'(dq_out), int'(pat(0)));
        pulse();
        check("R11 advance ce high", int'(dq_out), int'(pat(1)));

        // R10: command aborts single-page output
        @(negedge clk) cmd_latch = 1'b1;
        @(negedge clk) cmd_latch = 1'b0;
        @(negedge clk);
        check("R10 single abort ready", int'(rdy_n_busy), 1);
        check("R10 single abort dq", int'(dq_out), 0);

        // R7 R8: continuous mode
        one_page_only = 1'b0; chip_en_n = 1'b0;
        repeat (4) @(negedge clk);
        power_cycle(low);
        check("R3 busy length continuous", low, BC);
        repeat (PB - 1) pulse();
        check("R4 last byte page 0", int'(dq_out), int'(pat(PB - 1)));
        pulse();
        check("R7 busy on rollover", int'(rdy_n_busy), 0);
        wait_ready(low);
        check("R7 page 1 byte 0", int'(dq_out), int'(pat(PB)));
        repeat (PB) pulse();
        wait_ready(low);
        check("R7 page 2 byte 0", int'(dq_out), int'(pat(2 * PB)));
        repeat (PB - 1) pulse();
        check("R4 last byte last page", int'(dq_out), int'(pat(3 * PB - 1)));
        pulse();
        check("R8 end ready", int'(rdy_n_busy), 1);
        check("R8 end dq", int'(dq_out), 0);
        count_low(2 * BC, low);
        check("R8 no new busy", low, 0);

        // R9: chip enable high during busy
        @(negedge clk) pwr_good = 1'b0;
        repeat (3) @(negedge clk);
        pwr_good = 1'b1;
        repeat (5) @(negedge clk);
        chip_en_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 ce abort busy ready", int'(rdy_n_busy), 1);
        check("R9 ce abort busy dq", int'(dq_out), 0);
        chip_en_n = 1'b0;
        repeat (4) @(negedge clk);

        // R9: chip enable high during output
        power_cycle(low);
        pulse(); pulse();
        check("R4 byte 2 continuous", int'(dq_out), int'(pat(2)));
        chip_en_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 ce abort stream dq", int'(dq_out), 0);
        check("R9 ce abort stream ready", int'(rdy_n_busy), 1);
        chip_en_n = 1'b0;
        repeat (4) @(negedge clk);

        // R10: command during busy in continuous mode
        @(negedge clk) pwr_good = 1'b0;
        repeat (3) @(negedge clk);
        pwr_good = 1'b1;
        repeat (3) @(negedge clk);
        cmd_latch = 1'b1;
        @(negedge clk) cmd_latch = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 cmd abort busy ready", int'(rdy_n_busy), 1);
        check("R10 cmd abort busy dq", int'(dq_out), 0);

        // R1: power removed again
        pwr_good = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 off ready", int'(rdy_n_busy), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule